// File: doc/BRIEF.md
# Digital Variable-Gain Output Truncator

This block takes the 24-bit signed samples leaving a decimation filter and turns them into 16-bit signed samples. It applies a digital gain of 1, 2 or 4 (0, 6 or 12 dB). It does no multiplication. It only chooses which 16-bit slice of the 24-bit word reaches the output. When the gain is high, the top bits of the word are discarded. If those discarded bits carry real magnitude, the output clips to full scale and does not wrap.

The gain is steered by the larger of two amplitude estimates. One estimate is measured ahead of the gain stage and the other after it. When that maximum exceeds an upper threshold, the gain drops by one step. When it falls below a lower threshold, the gain rises by one step. Between the two thresholds the gain holds. Once the gain sits at unity and the level is still too high, a flag tells the converter's full-scale control to take over the attenuation.

All decisions happen only on accepted samples, so a gain change always falls on a sample boundary.

Top module: `dvga_trunc`

## Requirements
- R1: After reset, gain_code is 2 (gain 4), out_valid is 0 and atten_req is 0.
- R2: The gain_code values map as follows: 0 gives out_data = in_data[23:8] (gain 1), 1 gives in_data[22:7] (gain 2), and 2 gives in_data[21:6] (gain 4). Code 3 never appears.
- R3: When the bits discarded above the window do not all equal the sign bit, out_data saturates. A positive input gives 16'h7FFF and a negative input gives 16'h8000.
- R4: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R5: The control level is the larger of pre_level and post_level, compared as unsigned values.
- R6: On an accepted sample whose level exceeds HI_TH, gain_code drops by one in the following cycle, but never below 0.
- R7: On an accepted sample whose level is below LO_TH, gain_code rises by one in the following cycle, but never above 2. A level from LO_TH to HI_TH inclusive leaves gain_code unchanged.
- R8: Each sample is truncated with the gain_code in force when it is accepted, so a gain change applies from the next sample on. When in_valid is low, the estimates and in_data affect neither gain_code, out_data nor atten_req.
- R9: On each accepted sample, atten_req is set to 1 if the gain in force was 0 and the level exceeds HI_TH, and to 0 otherwise. It holds its value between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (24) | Signed wide sample from the decimator |
| pre_level | input | LVL_W (16) | Unsigned amplitude estimate taken before the gain |
| post_level | input | LVL_W (16) | Unsigned amplitude estimate taken after the gain |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OUT_W (16) | Signed truncated sample |
| gain_code | output | 2 | Current shift code (0: x1, 1: x2, 2: x4) |
| atten_req | output | 1 | Request for converter full-scale attenuation |

## Verification
The bench sends samples near the clipping edge at gain 2 and gain 4 in both polarities. A design that wraps or uses the wrong window would output a value with its sign flipped or with the wrong magnitude. It moves each estimate above the upper threshold on its own, to catch control that looks at only one of the two estimates. It pushes the gain against both ends of its range and holds the level exactly on each threshold, which exposes a missing clamp or an off-by-one comparison. It also changes the estimates heavily while in_valid is low, which catches gain that moves off a sample boundary.

// File: rtl/dvga_trunc.sv
module dvga_trunc #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int LVL_W = 16,
  parameter logic [LVL_W-1:0] HI_TH = 16'd16384,
  parameter logic [LVL_W-1:0] LO_TH = 16'd4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [LVL_W-1:0] pre_level,
  input  logic [LVL_W-1:0] post_level,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [1:0]       gain_code,
  output logic             atten_req
);
  localparam int LSB0 = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

  logic [LVL_W-1:0] level;
  logic             too_hi, too_lo;
  logic [OUT_W-1:0] win [3];
  logic [2:0]       ovf;
  logic [OUT_W-1:0] sliced;

  assign level  = (pre_level > post_level) ? pre_level : post_level;
  assign too_hi = level > HI_TH;
  assign too_lo = level < LO_TH;

  for (genvar g = 0; g < 3; g++) begin : g_win
    assign win[g] = in_data[IN_W-1-g -: OUT_W];
    if (g == 0) begin : g_nosat
      assign ovf[g] = 1'b0;
    end else begin : g_sat
      assign ovf[g] = (in_data[IN_W-1 -: g+1] != {(g+1){1'b0}}) &&
                      (in_data[IN_W-1 -: g+1] != {(g+1){1'b1}});
    end
  end

  always_comb begin
    sliced = win[0];
    case (gain_code)
      2'd1:    sliced = ovf[1] ? (in_data[IN_W-1] ? NEG_FS : POS_FS) : win[1];
      2'd2:    sliced = ovf[2] ? (in_data[IN_W-1] ? NEG_FS : POS_FS) : win[2];
      default: sliced = win[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      gain_code <= 2'd2;
      atten_req <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= sliced;
        atten_req <= (gain_code == 2'd0) && too_hi;
        if (too_hi && gain_code != 2'd0)
          gain_code <= gain_code - 2'd1;
        else if (too_lo && gain_code != 2'd2)
          gain_code <= gain_code + 2'd1;
      end
    end
  end

  wire unused_lsb = &{1'b0, in_data[LSB0-3:0]};
endmodule

module dvga_trunc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [1:0] gain_code,
  input logic       atten_req,
  input logic [15:0] out_data
);
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r4_no_extra_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code != 2'd3);
  a_r8_gain_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(gain_code) && $stable(atten_req) && $stable(out_data));
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (gain_code == $past(gain_code) || gain_code == $past(gain_code) + 2'd1 ||
                  gain_code + 2'd1 == $past(gain_code)));
  a_r9_flag_at_unity: assert property (@(posedge clk) disable iff (!rst_n)
    atten_req |-> gain_code == 2'd0);
endmodule

bind dvga_trunc dvga_trunc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .gain_code(gain_code), .atten_req(atten_req), .out_data(out_data)
);

// File: tb/dvga_trunc_test.sv
module dvga_trunc_test;
  localparam int HI = 16384;
  localparam int LO = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic [15:0] pre_level = '0, post_level = '0;
  logic        out_valid, atten_req;
  logic [15:0] out_data;
  logic [1:0]  gain_code;

  int tests = 0, fails = 0;
  int model_gain = 2;
  bit finished = 0;
  logic [15:0] q_data[$];
  int          q_gain[$];
  bit          q_flag[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  dvga_trunc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .pre_level(pre_level), .post_level(post_level), .out_valid(out_valid),
    .out_data(out_data), .gain_code(gain_code), .atten_req(atten_req)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_out(input logic [23:0] d, input int g);
    longint v = longint'($signed(d)) * (longint'(1) << g);
    if (v > 64'sd8388607) v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    return 16'(v >>> 8);
  endfunction

  task automatic send(input logic [23:0] d, input int pre, input int post, input string tag);
    int  lvl = (pre > post) ? pre : post;
    bit  flag = (model_gain == 0) && (lvl > HI);
    q_data.push_back(expect_out(d, model_gain));
    if (lvl > HI && model_gain > 0) model_gain--;
    else if (lvl < LO && model_gain < 2) model_gain++;
    q_gain.push_back(model_gain);
    q_flag.push_back(flag);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; pre_level = 16'(pre); post_level = 16'(post);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_data = 24'h7FFFFF; pre_level = 16'hFFFF; post_level = 16'(i * 7);
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) begin
        check("R4 unexpected out_valid", 1, 0);
      end else begin
        string t = q_tag.pop_front();
        check({t, " data"}, out_data, q_data.pop_front());
        check({t, " gain R6/R7"}, gain_code, q_gain.pop_front());
        check({t, " flag R9"}, atten_req, q_flag.pop_front());
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gain", gain_code, 2);
    check("R1 valid", out_valid, 0);
    check("R1 flag", atten_req, 0);
    rst_n = 1'b1;
    // R2 gain 4 window, R3 saturation at gain 4
    send(24'h001234, 100, 200, "R2 x4 small");
    send(24'h1FFFC0, 100, 200, "R2 x4 edge pos");
    send(24'h200000, 100, 200, "R3 x4 sat pos");
    send(24'hC00000, 100, 200, "R3 x4 sat neg");
    send(24'hE00000, 100, 200, "R2 x4 edge neg");
    // R5 pre only pushes down, R8 new gain on next sample
    send(24'h200000, 20000, 10, "R5 pre high");
    send(24'h200000, 5000, 5000, "R8 x2 next sample");
    send(24'h400000, HI, LO, "R7 threshold hold x2 sat");
    send(24'hBFFFFF, HI, 0, "R3 x2 sat neg");
    // R5 post only pushes down
    send(24'h3FFF00, 0, 30000, "R5 post high");
    send(24'h812345, 30000, 0, "R2 x1 window");
    send(24'h7FFFFF, 65535, 0, "R9 flag at unity");
    idle(6);
    tests++;
    if (gain_code != 0 || atten_req != 1) begin
      fails++;
      $display("FAIL R8 idle hold actual=%0d/%0d expected=0/1", gain_code, atten_req);
    end
    send(24'h123456, 8000, 8000, "R9 flag clears mid");
    send(24'h123456, LO - 1, 0, "R7 rise 1");
    send(24'h123456, 0, 0, "R7 rise 2");
    send(24'h0ABCDE, 0, 0, "R7 clamp top");
    send(24'h0ABCDE, LO, LO, "R7 LO inclusive hold");
    send(24'hFFF000, HI + 1, 0, "R6 step down");
    send(24'hFFF000, HI + 1, 0, "R6 step down 2");
    send(24'hFFF000, HI + 1, HI + 1, "R6 clamp bottom");
    idle(4);
    tests++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R4 missing outputs actual=%0d expected=0", q_data.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule